// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block turns parallel 24-bit audio samples into one serial data line. It runs on a fast system clock and takes the bit clock and the frame clock as inputs from elsewhere. Both clocks are sampled on the system clock, so they must be synchronous to it, and every phase of the bit clock must last at least three system clock cycles. After each falling edge of the bit clock, the block drives the next serial bit. It has five framing modes: two-channel I2S, left-justified, right-justified with a 24-bit or a 16-bit word, and time-division multiplex with four or eight slots. For each mode it applies that mode's data delay and slot placement. Every bit position outside a word is driven as zero.

Samples come in through a ready/valid load port, one word per channel or slot, in channel order. A sample that is loaded during one frame is sent in the next frame. At each frame start the loaded samples move into the words being sent. A channel that received no new sample repeats its old word, and a flag reports the underrun for that frame.

Top module: `audtx`

## Requirements
- R1: While reset is low and in the first cycle after it is released, serialData is 0, underrun is 0 and sampleReady is 1.
- R2: The effective bit clock is bitClkIn XOR cfgBitClkInv. serialData changes only while the effective bit clock is low. It takes its new value two system cycles after the system clock detects a falling edge of the effective bit clock, and it then holds until the next falling edge.
- R3: cfgFormat encoding is 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = TDM. In I2S mode the left half of the frame is the low level of the effective frame clock. In left-justified mode the left half is the high level. Every level change of the frame clock starts a half. The first bit of a half is sent 1 bit clock after the start of the half in I2S mode and 0 bit clocks after it in left-justified mode. Bits go out MSB first. Channel 0 (the first sample loaded) is sent in the left half and channel 1 in the right half.
- R4: In right-justified mode the left half is the high level of the frame clock. With cfgRj16 = 0 the word is delayed by 8 bit clocks and all 24 bits are sent. With cfgRj16 = 1 the word is delayed by 16 bit clocks and only sample bits 23..8 are sent.
- R5: In TDM mode a rising edge of the effective frame clock starts a frame, and a falling edge has no effect. This works with a one-bit pulse or with a 50% clock. The slot count is 8 when cfgTdm8 = 1 and 4 otherwise. Slot k covers bit positions 1+32k to 32+32k, counted from the start edge as position 0. A slot carries the 24 bits of sample k, MSB first, followed by 8 zero bits. Slots 0..3 therefore fill the first 129 positions and slots 4..7 the next 128.
- R6: Positions after the last slot are driven as 0. In two-channel modes, positions past the delay plus the word length are also driven as 0. Any frame length is accepted.
- R7: Loads are accepted in channel order, starting at channel 0, whenever sampleValid and sampleReady are both high. The channel count is 2 in two-channel modes. sampleReady goes low once that many samples are waiting and stays low until a frame start. It is also low in the one cycle in which the waiting samples move into the sending words. A load held during that cycle is accepted one cycle later and counts toward the following frame.
- R8: At each frame start, a channel that was not loaded keeps its previous word. underrun becomes 1 for that frame if fewer samples than the channel count were waiting, and 0 otherwise. It updates one cycle before the frame's first bit appears.
- R9: cfgFrameInv = 1 inverts the frame clock and cfgBitClkInv = 1 inverts the bit clock before any edge detection. The effective clocks then behave exactly as described above.
- R10: If a half holds fewer bit clocks than the delay plus the word length, the word is cut off at the end of the half. The next half starts with its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgFormat | input | 2 | Framing mode: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| cfgTdm8 | input | 1 | TDM slot count: 1 selects 8 slots, 0 selects 4 |
| cfgRj16 | input | 1 | Right-justified word: 1 selects 16 bits, 0 selects 24 |
| cfgFrameInv | input | 1 | Inverts the frame clock |
| cfgBitClkInv | input | 1 | Inverts the bit clock |
| bitClkIn | input | 1 | Bit clock, synchronous to clk |
| frameClkIn | input | 1 | Frame clock, synchronous to clk |
| sampleData | input | 24 | Sample word to load, two's complement |
| sampleValid | input | 1 | Load request |
| sampleReady | output | 1 | Load can be accepted |
| serialData | output | 1 | Serial data line |
| underrun | output | 1 | Set for a frame that repeated at least one old sample |

## Verification
A frame start and a load can fall on the same cycle. When they do, the sample must neither be lost nor reach the frame that is already starting. The bench provokes this by raising sampleValid in the exact cycle in which the waiting samples move into the sending words. It expects sampleReady to be low there, and high one cycle later. The frame that starts must still report an underrun. The next frame must carry the held sample in channel 0 and repeat the old word in channel 1.

// File: rtl/audtx_pkg.sv
`timescale 1ns/1ps
package audtx_pkg;

  parameter int SLOT_BITS = 32;
  parameter int MAX_SLOTS = 8;
  parameter int SLOT_LOG  = $clog2(SLOT_BITS);
  parameter int POS_W     = $clog2(MAX_SLOTS * SLOT_BITS) + 1;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             copy;   // move waiting samples into sending words
    logic             shift;  // drive the bit for pos onto the line
    logic             half;   // 0 = left half, 1 = right half
    logic [POS_W-1:0] pos;    // bit position inside the half or frame
  } strobe_t;

endpackage

// File: rtl/audtx_ctrl.sv
`timescale 1ns/1ps
module audtx_ctrl
  import audtx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  fmt_e    fmt,
  input  logic    cfgFrameInv,
  input  logic    cfgBitClkInv,
  input  logic    bitClkIn,
  input  logic    frameClkIn,
  output strobe_t strb
);

  localparam logic [POS_W-1:0] POS_LAST = '1;

  logic bclkEff, bclkPrev, frameEff, framePrev;
  logic fall, levelChange, startEdge, posRestart, startLevel;
  logic fallD, copyQ, shiftQ, halfQ;
  logic [POS_W-1:0] posQ;

  always_comb begin
    bclkEff     = bitClkIn ^ cfgBitClkInv;
    frameEff    = frameClkIn ^ cfgFrameInv;
    fall        = bclkPrev & ~bclkEff;
    // only I2S opens its frame on the low level
    startLevel  = (fmt != FMT_I2S);
    levelChange = (frameEff != framePrev);
    startEdge   = levelChange && (frameEff == startLevel);
    // TDM counts across the whole frame, two-channel modes restart each half
    posRestart  = (fmt == FMT_TDM) ? startEdge : levelChange;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev  <= 1'b0;
      framePrev <= 1'b0;
      posQ      <= POS_LAST;
      halfQ     <= 1'b0;
      copyQ     <= 1'b0;
      fallD     <= 1'b0;
      shiftQ    <= 1'b0;
    end else begin
      bclkPrev <= bclkEff;
      copyQ    <= fall && startEdge;
      fallD    <= fall;
      shiftQ   <= fallD;
      if (fall) begin
        framePrev <= frameEff;
        halfQ     <= (frameEff != startLevel);
        if (posRestart)
          posQ <= '0;
        else if (posQ != POS_LAST)
          posQ <= posQ + 1'b1;
      end
    end
  end

  always_comb begin
    strb.copy  = copyQ;
    strb.shift = shiftQ;
    strb.half  = halfQ;
    strb.pos   = posQ;
  end

endmodule

// File: rtl/audtx_datapath.sv
`timescale 1ns/1ps
module audtx_datapath
  import audtx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  fmt_e                fmt,
  input  logic                cfgTdm8,
  input  logic                cfgRj16,
  input  strobe_t             strb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  output logic                sampleReady,
  output logic                serialData,
  output logic                underrun
);

  localparam int IDX_W    = $clog2(MAX_SLOTS);
  localparam int CNT_W    = IDX_W + 1;
  localparam int SEL_W    = $clog2(SAMPLE_W);
  localparam int RJ_SHORT = SLOT_BITS - SAMPLE_W;
  localparam int RJ_LONG  = SLOT_BITS / 2;

  logic [SAMPLE_W-1:0] stageQ  [MAX_SLOTS];
  logic [SAMPLE_W-1:0] activeQ [MAX_SLOTS];
  logic [CNT_W-1:0]    loadCnt, chanCnt;
  logic                accept, inWord, bitNext, underrunQ, serialQ;
  logic [IDX_W-1:0]    slotSel;
  logic [SEL_W-1:0]    bitSel;
  logic [SAMPLE_W-1:0] wordSel;
  int                  nChI, posI, delayI, wordI, dI, slotI, withinI;

  // load side
  always_comb begin
    nChI = (fmt == FMT_TDM) ? (cfgTdm8 ? MAX_SLOTS : MAX_SLOTS / 2) : 2;
    chanCnt     = CNT_W'(nChI);
    sampleReady = (loadCnt < chanCnt) && !strb.copy;
    accept      = sampleValid && sampleReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadCnt   <= '0;
      underrunQ <= 1'b0;
      for (int i = 0; i < MAX_SLOTS; i++) begin
        stageQ[i]  <= '0;
        activeQ[i] <= '0;
      end
    end else begin
      if (strb.copy) begin
        loadCnt   <= '0;
        underrunQ <= (loadCnt < chanCnt);
      end else if (accept) begin
        loadCnt <= loadCnt + 1'b1;
      end
      for (int i = 0; i < MAX_SLOTS; i++) begin
        if (accept && loadCnt == CNT_W'(i))
          stageQ[i] <= sampleData;
        if (strb.copy && loadCnt > CNT_W'(i))
          activeQ[i] <= stageQ[i];
      end
    end
  end

  // bit selection for the current position
  always_comb begin
    posI = int'(strb.pos);
    case (fmt)
      FMT_LJ:  delayI = 0;
      FMT_RJ:  delayI = cfgRj16 ? RJ_LONG : RJ_SHORT;
      default: delayI = 1;
    endcase
    wordI   = (fmt == FMT_RJ) ? (SLOT_BITS - delayI) : SAMPLE_W;
    dI      = 0;
    slotI   = 0;
    withinI = 0;
    inWord  = 1'b0;
    if (posI >= delayI) begin
      dI = posI - delayI;
      if (fmt == FMT_TDM) begin
        slotI   = dI >> SLOT_LOG;
        withinI = dI % SLOT_BITS;
        inWord  = (slotI < nChI) && (withinI < SAMPLE_W);
      end else begin
        slotI   = strb.half ? 1 : 0;
        withinI = dI;
        inWord  = (dI < wordI);
      end
    end
    slotSel = IDX_W'(slotI);
    bitSel  = SEL_W'(SAMPLE_W - 1 - withinI);
    wordSel = activeQ[slotSel];
    bitNext = inWord & wordSel[bitSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      serialQ <= 1'b0;
    else if (strb.shift)
      serialQ <= bitNext;
  end

  assign serialData = serialQ;
  assign underrun   = underrunQ;

endmodule

// File: rtl/audtx.sv
`timescale 1ns/1ps
module audtx
  import audtx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgFormat,
  input  logic                cfgTdm8,
  input  logic                cfgRj16,
  input  logic                cfgFrameInv,
  input  logic                cfgBitClkInv,
  input  logic                bitClkIn,
  input  logic                frameClkIn,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  output logic                sampleReady,
  output logic                serialData,
  output logic                underrun
);

  fmt_e    fmt;
  strobe_t strb;

  assign fmt = fmt_e'(cfgFormat);

  audtx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fmt          (fmt),
    .cfgFrameInv  (cfgFrameInv),
    .cfgBitClkInv (cfgBitClkInv),
    .bitClkIn     (bitClkIn),
    .frameClkIn   (frameClkIn),
    .strb         (strb)
  );

  audtx_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .fmt         (fmt),
    .cfgTdm8     (cfgTdm8),
    .cfgRj16     (cfgRj16),
    .strb        (strb),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .serialData  (serialData),
    .underrun    (underrun)
  );

endmodule

// File: rtl/audtx_checker.sv
`timescale 1ns/1ps
module audtx_checker (
  input logic clk,
  input logic rstN,
  input logic cfgBitClkInv,
  input logic bitClkIn,
  input logic serialData,
  input logic underrun,
  input logic sampleReady
);

  logic bclkEff;
  assign bclkEff = bitClkIn ^ cfgBitClkInv;

  // R1: outputs idle during reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (serialData == 1'b0 && underrun == 1'b0 && sampleReady == 1'b1));

  // R2: the line never moves while the bit clock is high
  p_change_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $changed(serialData) |-> !bclkEff);

  // R8: underrun only updates just after a bit clock fall
  p_underrun_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    $changed(underrun) |-> ($past(bclkEff, 3) && !$past(bclkEff, 2)));

  // R7: ready reopens only right after a bit clock fall that started a frame
  p_ready_reopen_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleReady) |-> ($past(bclkEff, 3) && !$past(bclkEff, 2)));

endmodule

bind audtx audtx_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgBitClkInv (cfgBitClkInv),
  .bitClkIn     (bitClkIn),
  .serialData   (serialData),
  .underrun     (underrun),
  .sampleReady  (sampleReady)
);

// File: tb/audtx_bench.sv
`timescale 1ns/1ps
module audtx_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgFormat = 2'd0;
  logic        cfgTdm8 = 1'b0, cfgRj16 = 1'b0, cfgFrameInv = 1'b0, cfgBitClkInv = 1'b0;
  logic        bitClkIn = 1'b1, frameClkIn = 1'b1;
  logic [23:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady, serialData, underrun;

  int nTests = 0, nFail = 0;
  bit done = 0;
  logic [23:0] actM [8];
  logic [23:0] pendM [8];
  int pendCnt = 0;

  always #4 clk = ~clk;

  audtx u_audtx (
    .clk(clk), .rstN(rstN), .cfgFormat(cfgFormat), .cfgTdm8(cfgTdm8), .cfgRj16(cfgRj16),
    .cfgFrameInv(cfgFrameInv), .cfgBitClkInv(cfgBitClkInv), .bitClkIn(bitClkIn),
    .frameClkIn(frameClkIn), .sampleData(sampleData), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .serialData(serialData), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit startLvl();
    return cfgFormat != 2'd0;
  endfunction

  function automatic int nCh();
    if (cfgFormat == 2'd3) return cfgTdm8 ? 8 : 4;
    return 2;
  endfunction

  function automatic bit expBit(input int p, input int n);
    int d, q, h, dly, wl, slot, w;
    if (cfgFormat == 2'd3) begin
      if (p < 1) return 1'b0;
      d = p - 1; slot = d / 32; w = d % 32;
      if (slot < nCh() && w < 24) return actM[slot][23 - w];
      return 1'b0;
    end
    h = (p >= n / 2) ? 1 : 0;
    q = h ? p - n / 2 : p;
    case (cfgFormat)
      2'd0: dly = 1;
      2'd1: dly = 0;
      default: dly = cfgRj16 ? 16 : 8;
    endcase
    wl = (cfgFormat == 2'd2) ? 32 - dly : 24;
    if (q < dly) return 1'b0;
    d = q - dly;
    if (d < wl) return actM[h][23 - d];
    return 1'b0;
  endfunction

  task automatic setBus(input bit effB, input bit effF);
    bitClkIn   = effB ^ cfgBitClkInv;
    frameClkIn = effF ^ cfgFrameInv;
  endtask

  task automatic bitCycle(input bit effF);
    @(negedge clk); setBus(1'b0, effF);
    repeat (3) @(negedge clk);
    @(negedge clk); setBus(1'b1, effF);
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input int fmt, input bit t8, input bit r16, input bit fInv, input bit bInv);
    @(negedge clk);
    cfgFormat = 2'(fmt); cfgTdm8 = t8; cfgRj16 = r16; cfgFrameInv = fInv; cfgBitClkInv = bInv;
    setBus(1'b1, ~startLvl());
    bitCycle(~startLvl());
    bitCycle(~startLvl());
  endtask

  task automatic pushSample(input logic [23:0] v);
    @(negedge clk); sampleValid = 1'b1; sampleData = v;
    while (!sampleReady) @(negedge clk);
    @(negedge clk); sampleValid = 1'b0;
    pendM[pendCnt] = v; pendCnt++;
  endtask

  task automatic loadN(input int k);
    for (int i = 0; i < k; i++) pushSample(24'($urandom));
  endtask

  task automatic runFrame(input int n, input bit pulse, input bit conc, input string tag);
    bit effF, expUnd, got;
    logic [23:0] x;
    for (int p = 0; p < n; p++) begin
      if (cfgFormat == 2'd3) effF = pulse ? (p == 0) : (p < n / 2);
      else effF = (p < n / 2) ? startLvl() : ~startLvl();
      @(negedge clk); setBus(1'b0, effF);
      if (p == 0) begin
        for (int i = 0; i < pendCnt; i++) actM[i] = pendM[i];
        expUnd = (pendCnt < nCh());
        pendCnt = 0;
      end
      if (p == 0 && conc) begin
        x = 24'($urandom);
        @(negedge clk); sampleValid = 1'b1; sampleData = x;
        chk(sampleReady == 1'b0, "R7 load blocked in frame-start cycle", int'(sampleReady), 0);
        @(negedge clk);
        chk(sampleReady == 1'b1, "R7 ready after frame-start cycle", int'(sampleReady), 1);
        @(negedge clk); sampleValid = 1'b0;
        pendM[0] = x; pendCnt = 1;
      end else begin
        repeat (3) @(negedge clk);
      end
      got = serialData;
      chk(got == expBit(p, n), tag, int'(got), int'(expBit(p, n)));
      if (p == 0) begin
        chk(underrun == expUnd, "R8 underrun flag", int'(underrun), int'(expUnd));
        if (!conc) chk(sampleReady == 1'b1, "R7 ready at frame start", int'(sampleReady), 1);
      end
      @(negedge clk); setBus(1'b1, effF);
      repeat (3) @(negedge clk);
      chk(serialData == got, "R2 line held while bit clock high", int'(serialData), int'(got));
    end
  endtask

  task automatic fmtTag(output string t);
    case (cfgFormat)
      2'd0, 2'd1: t = "R3 two-channel bit";
      2'd2: t = "R4 right-justified bit";
      default: t = "R5 TDM bit";
    endcase
  endtask

  initial begin
    string t;
    int fmt, n, k;
    bit t8, r16, pulse;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) actM[i] = '0;
    repeat (4) @(negedge clk);
    chk(serialData == 1'b0 && underrun == 1'b0 && sampleReady == 1'b1, "R1 reset state",
        {serialData, underrun, sampleReady}, 3'b001);
    @(negedge clk); rstN = 1'b1;
    chk(serialData == 1'b0 && underrun == 1'b0 && sampleReady == 1'b1, "R1 after release",
        {serialData, underrun, sampleReady}, 3'b001);

    // I2S, full loads
    setCfg(0, 0, 0, 0, 0);
    for (int f = 0; f < 2; f++) begin loadN(2); runFrame(64, 0, 0, "R3 I2S bit"); end
    // left-justified with padding, then a short frame that truncates
    setCfg(1, 0, 0, 0, 0);
    loadN(2); runFrame(64, 0, 0, "R6 left-justified padding");
    loadN(2); runFrame(32, 0, 0, "R10 truncated half");
    // right-justified, both word sizes
    setCfg(2, 0, 0, 0, 0);
    loadN(2); runFrame(64, 0, 0, "R4 right-justified 24");
    setCfg(2, 0, 1, 0, 0);
    loadN(2); runFrame(64, 0, 0, "R4 right-justified 16");
    // TDM 8 pulse and TDM 4 with a long frame
    setCfg(3, 1, 0, 0, 0);
    loadN(8); runFrame(256, 1, 0, "R5 TDM8 slot bit");
    setCfg(3, 0, 0, 0, 0);
    loadN(4); runFrame(160, 0, 0, "R6 TDM4 padding");
    // underrun: partial load repeats old words
    loadN(1); runFrame(128, 1, 0, "R8 repeated slot bit");
    runFrame(128, 1, 0, "R8 nothing loaded");
    // full stage ignores extra loads
    setCfg(1, 0, 0, 0, 0);
    loadN(2);
    chk(sampleReady == 1'b0, "R7 ready low when stage full", int'(sampleReady), 0);
    @(negedge clk); sampleValid = 1'b1; sampleData = 24'h5A5A5A;
    repeat (4) begin
      @(negedge clk);
      chk(sampleReady == 1'b0, "R7 extra load refused", int'(sampleReady), 0);
    end
    sampleValid = 1'b0;
    runFrame(64, 0, 0, "R7 extra load not sent");
    // load colliding with the frame start
    loadN(1); runFrame(64, 0, 1, "R7 collision frame");
    runFrame(64, 0, 0, "R7 held sample in next frame");
    // inverted clocks
    setCfg(0, 0, 0, 1, 1);
    for (int f = 0; f < 2; f++) begin loadN(2); runFrame(48, 0, 0, "R9 inverted clocks"); end

    // constrained random frames
    for (int f = 0; f < 14; f++) begin
      fmt = $urandom_range(3); t8 = 1'($urandom); r16 = 1'($urandom); pulse = 1'($urandom);
      setCfg(fmt, t8, r16, 1'($urandom), 1'($urandom));
      if (fmt == 3) n = t8 ? 256 : 128 + 32 * $urandom_range(2);
      else n = 32 + 8 * $urandom_range(4);
      k = $urandom_range(nCh());
      loadN(k);
      fmtTag(t);
      runFrame(n, pulse, 0, t);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule